// File: doc/BRIEF.md
# Endian Byte-Lane Steering Unit

This block sits between a little-endian 32-bit host datapath and a local bus whose width (32 or 16 bits) and byte order (little or big) are set by three configuration inputs. On the write side it takes one host word with per-byte enables. It emits either one bus beat (32-bit bus) or two bus beats (16-bit bus), with every byte and its enable moved to the lane the selected mode calls for. Lanes that carry no byte are driven with zero data and a deasserted enable.

On the read side it accepts one or two bus beats, depending on the mode. It pulls each byte out of the lane the same mapping assigns to it and returns a single little-endian host word. In big-endian 16-bit mode, a configuration bit places both beats on either the upper or the lower half of the bus. Byte addresses keep their meaning in every mode; the bytes are never simply swapped. Both sides use valid/ready handshakes. Each path latches the configuration when it starts a word, so a change that arrives partway through a word only takes effect on the next word.

Top module: `endian_lane_steer`

## Requirements
- R1: With cfg_bus16=0 and cfg_big=0, a host word leaves as one beat with byte k on bus_wdata[8k+7:8k] and bus_wbe[k]=wr_be[k].
- R2: With cfg_bus16=0 and cfg_big=1, a host word leaves as one beat with host byte 0 on bits [31:24], byte 1 on [23:16], byte 2 on [15:8] and byte 3 on [7:0].
- R3: With cfg_bus16=1, cfg_big=1 and cfg_upper=1, the first beat carries byte 0 on [31:24] and byte 1 on [23:16]. The second beat carries byte 2 on [31:24] and byte 3 on [23:16]. Bits [15:0] are zero and bus_wbe[1:0]=0 on both beats.
- R4: With cfg_bus16=1, cfg_big=1 and cfg_upper=0, the first beat carries byte 0 on [15:8] and byte 1 on [7:0]. The second beat carries byte 2 on [15:8] and byte 3 on [7:0]. Bits [31:16] are zero and bus_wbe[3:2]=0.
- R5: With cfg_bus16=1 and cfg_big=0, the first beat carries byte 0 on [7:0] and byte 1 on [15:8]. The second beat carries byte 2 on [7:0] and byte 3 on [15:8]. The upper half and bus_wbe[3:2] are zero, and cfg_upper has no effect.
- R6: Each lane's bus_wbe bit equals the wr_be bit of the host byte placed in that lane, and it is 0 for lanes that carry no byte.
- R7: A write accepted at a clock edge (wr_valid and wr_ready both 1) raises bus_wvalid from the next cycle. wr_ready stays 0 until the last beat of that word is accepted. bus_wvalid, bus_wdata and bus_wbe hold steady while bus_wready is 0.
- R8: On reads, each accepted beat is unpacked with the lane mapping of R1 to R5, placing each byte back at its little-endian host position. rd_valid rises the cycle after the final beat (the first beat on a 32-bit bus, the second beat on a 16-bit bus).
- R9: While rd_valid is 1, rd_data holds until rd_ready is 1, and bus_rready is 0.
- R10: Each path samples the configuration only when it starts a word. A configuration change between the two beats of a 16-bit word does not alter that word.
- R11: While rst is 1 and after its release, bus_wvalid=0, rd_valid=0, wr_ready=1 and bus_rready=1 until traffic arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 32-bit bus |
| cfg_big | input | 1 | 1 = big-endian bus, 0 = little-endian |
| cfg_upper | input | 1 | 16-bit big-endian only: 1 = upper half, 0 = lower half |
| wr_valid | input | 1 | Host write word valid |
| wr_ready | output | 1 | Block can take a host write word |
| wr_data | input | DATA_W | Host write word, little-endian |
| wr_be | input | DATA_W/8 | Host per-byte enables |
| bus_wvalid | output | 1 | Bus write beat valid |
| bus_wready | input | 1 | Bus accepts the write beat |
| bus_wdata | output | DATA_W | Bus write beat data, lane-steered |
| bus_wbe | output | DATA_W/8 | Bus write beat lane enables |
| bus_rvalid | input | 1 | Bus read beat valid |
| bus_rready | output | 1 | Block can take a read beat |
| bus_rdata | input | DATA_W | Bus read beat data |
| rd_valid | output | 1 | Assembled host read word valid |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | DATA_W | Assembled host read word, little-endian |

## Verification
The bench builds the block at its default DATA_W of 32, which is the only width at which the lane positions in the requirements are defined. It therefore reaches all five lane mappings, each with random data, random byte enables and random back-pressure on both handshakes. The 16-bit little-endian mode is run with cfg_upper both set and clear. Directed sequences flip the configuration between the two beats of a 16-bit word, on the write side and on the read side.

// File: rtl/els_pkg.sv
package els_pkg;

  typedef struct packed {
    logic bus16;
    logic big;
    logic upper;
  } els_cfg_t;

  // Bus lane that carries host byte b for configuration c, with nb lanes in total.
  function automatic int unsigned els_lane(els_cfg_t c, int unsigned b, int unsigned nb);
    int unsigned h;
    h = nb / 2;
    if (!c.bus16)     return c.big ? (nb - 1 - b) : b;
    else if (!c.big)  return b % h;
    else if (c.upper) return nb - 1 - (b % h);
    else              return h - 1 - (b % h);
  endfunction

  // Beat (0 or 1) in which host byte b travels.
  function automatic int unsigned els_beat(els_cfg_t c, int unsigned b, int unsigned nb);
    return c.bus16 ? (b / (nb / 2)) : 0;
  endfunction

endpackage

// File: rtl/els_lane_map.sv
module els_lane_map
  import els_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  els_cfg_t              cfg,
  input  logic                  beat,
  input  logic [DATA_W-1:0]     host_data,
  input  logic [DATA_W/8-1:0]   host_be,
  output logic [DATA_W-1:0]     lane_data,
  output logic [DATA_W/8-1:0]   lane_be
);
  localparam int unsigned NBYTE = DATA_W / 8;

  // Every lane starts empty; a byte belonging to this beat claims its lane.
  always_comb begin
    lane_data = '0;
    lane_be   = '0;
    for (int unsigned ln = 0; ln < NBYTE; ln++) begin
      for (int unsigned b = 0; b < NBYTE; b++) begin
        if (els_lane(cfg, b, NBYTE) == ln &&
            ((els_beat(cfg, b, NBYTE) != 0) == beat)) begin
          lane_data[ln*8 +: 8] = host_data[b*8 +: 8];
          lane_be[ln]          = host_be[b];
        end
      end
    end
  end

endmodule

// File: rtl/els_wr_split.sv
module els_wr_split
  import els_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  els_cfg_t             cfg_in,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DATA_W/8-1:0]  wr_be,
  output logic                 bus_wvalid,
  input  logic                 bus_wready,
  output logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W/8-1:0]  bus_wbe
);
  localparam int NBYTE = DATA_W / 8;
  localparam int HALF  = NBYTE / 2;
  localparam int HW    = DATA_W / 2;

  logic                busy;
  logic                beat_q;
  els_cfg_t            cfg_q;
  logic [DATA_W-1:0]   word_q;
  logic [NBYTE-1:0]    be_q;
  logic [DATA_W-1:0]   data_q;
  logic [NBYTE-1:0]    lbe_q;

  // Idle: steer beat 0 of the incoming word with live config.
  // Busy: steer beat 1 of the held word with latched config.
  els_cfg_t            map_cfg;
  logic [DATA_W-1:0]   map_src;
  logic [NBYTE-1:0]    map_src_be;
  logic [DATA_W-1:0]   map_data;
  logic [NBYTE-1:0]    map_be;

  assign map_cfg    = busy ? cfg_q  : cfg_in;
  assign map_src    = busy ? word_q : wr_data;
  assign map_src_be = busy ? be_q   : wr_be;

  els_lane_map #(.DATA_W(DATA_W)) u_map (
    .cfg       (map_cfg),
    .beat      (busy),
    .host_data (map_src),
    .host_be   (map_src_be),
    .lane_data (map_data),
    .lane_be   (map_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      beat_q <= 1'b0;
      cfg_q  <= '0;
      word_q <= '0;
      be_q   <= '0;
      data_q <= '0;
      lbe_q  <= '0;
    end else if (!busy) begin
      if (wr_valid) begin
        busy   <= 1'b1;
        beat_q <= 1'b0;
        cfg_q  <= cfg_in;
        word_q <= wr_data;
        be_q   <= wr_be;
        data_q <= map_data;
        lbe_q  <= map_be;
      end
    end else if (bus_wready) begin
      if (cfg_q.bus16 && !beat_q) begin
        beat_q <= 1'b1;
        data_q <= map_data;
        lbe_q  <= map_be;
      end else begin
        busy   <= 1'b0;
        beat_q <= 1'b0;
      end
    end
  end

  assign wr_ready   = !busy;
  assign bus_wvalid = busy;
  assign bus_wdata  = data_q;
  assign bus_wbe    = lbe_q;

  AST_WR_TAKE: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready |=> bus_wvalid && !wr_ready); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && !bus_wready |=> bus_wvalid && $stable(bus_wdata) && $stable(bus_wbe)); // R7
  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && bus_wready && !cfg_q.bus16 |=> !bus_wvalid); // R1
  AST_TWO_BEAT: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && bus_wready && cfg_q.bus16 && !beat_q |=> bus_wvalid && !wr_ready); // R7
  AST_UPPER_HALF: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && cfg_q.bus16 && cfg_q.big && cfg_q.upper
      |-> bus_wdata[HW-1:0] == '0 && bus_wbe[HALF-1:0] == '0); // R3
  AST_LOWER_HALF: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && cfg_q.bus16 && cfg_q.big && !cfg_q.upper
      |-> bus_wdata[DATA_W-1:HW] == '0 && bus_wbe[NBYTE-1:HALF] == '0); // R4
  AST_LE16_HALF: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid && cfg_q.bus16 && !cfg_q.big
      |-> bus_wdata[DATA_W-1:HW] == '0 && bus_wbe[NBYTE-1:HALF] == '0); // R5
  AST_WR_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(cfg_q))); // R10

endmodule

// File: rtl/els_rd_pack.sv
module els_rd_pack
  import els_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  els_cfg_t             cfg_in,
  input  logic                 bus_rvalid,
  output logic                 bus_rready,
  input  logic [DATA_W-1:0]    bus_rdata,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int unsigned NBYTE = DATA_W / 8;

  logic               full;
  logic               got_first;
  els_cfg_t           cfg_q;
  logic [DATA_W-1:0]  acc;
  els_cfg_t           cfg_eff;
  logic [DATA_W-1:0]  nxt;
  logic [7:0]         nxt_byte [NBYTE];

  assign cfg_eff = got_first ? cfg_q : cfg_in;

  // Each host byte either takes its lane from this beat or keeps its value.
  for (genvar gb = 0; gb < NBYTE; gb++) begin : g_byte
    always_comb begin
      nxt_byte[gb] = acc[gb*8 +: 8];
      if ((els_beat(cfg_eff, gb, NBYTE) != 0) == got_first) begin
        for (int unsigned ln = 0; ln < NBYTE; ln++) begin
          if (els_lane(cfg_eff, gb, NBYTE) == ln)
            nxt_byte[gb] = bus_rdata[ln*8 +: 8];
        end
      end
    end
    assign nxt[gb*8 +: 8] = nxt_byte[gb];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 1'b0;
      got_first <= 1'b0;
      cfg_q     <= '0;
      acc       <= '0;
    end else if (full) begin
      if (rd_ready) full <= 1'b0;
    end else if (bus_rvalid) begin
      acc <= nxt;
      if (!got_first) cfg_q <= cfg_in;
      if (cfg_eff.bus16 && !got_first) begin
        got_first <= 1'b1;
      end else begin
        got_first <= 1'b0;
        full      <= 1'b1;
      end
    end
  end

  assign bus_rready = !full;
  assign rd_valid   = full;
  assign rd_data    = acc;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && !bus_rready); // R9
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid && bus_rready && !got_first && !cfg_in.bus16 |=> rd_valid); // R8
  AST_RD_SECOND: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid && bus_rready && got_first |=> rd_valid); // R8
  AST_RD_FIRST_WAIT: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid && bus_rready && !got_first && cfg_in.bus16 |=> !rd_valid); // R8
  AST_RD_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    got_first |=> (!got_first || $stable(cfg_q))); // R10

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import els_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_bus16,
  input  logic                 cfg_big,
  input  logic                 cfg_upper,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DATA_W/8-1:0]  wr_be,
  output logic                 bus_wvalid,
  input  logic                 bus_wready,
  output logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W/8-1:0]  bus_wbe,
  input  logic                 bus_rvalid,
  output logic                 bus_rready,
  input  logic [DATA_W-1:0]    bus_rdata,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data
);
  els_cfg_t cfg;
  assign cfg = '{bus16: cfg_bus16, big: cfg_big, upper: cfg_upper};

  els_wr_split #(.DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .cfg_in     (cfg),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .bus_wvalid (bus_wvalid),
    .bus_wready (bus_wready),
    .bus_wdata  (bus_wdata),
    .bus_wbe    (bus_wbe)
  );

  els_rd_pack #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .cfg_in     (cfg),
    .bus_rvalid (bus_rvalid),
    .bus_rready (bus_rready),
    .bus_rdata  (bus_rdata),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !bus_wvalid && !rd_valid && wr_ready && bus_rready); // R11

endmodule

// File: tb/sim_endian_lane_steer.sv
`timescale 1ns/1ps
module sim_endian_lane_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bus16 = 0, cfg_big = 0, cfg_upper = 0;
  logic wr_valid = 0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic bus_wready = 0;
  logic bus_rvalid = 0;
  logic [31:0] bus_rdata = '0;
  logic rd_ready = 0;
  logic wr_ready, bus_wvalid, bus_rready, rd_valid;
  logic [31:0] bus_wdata, rd_data;
  logic [3:0]  bus_wbe;

  endian_lane_steer #(.DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .cfg_bus16(cfg_bus16), .cfg_big(cfg_big), .cfg_upper(cfg_upper),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be),
    .bus_wvalid(bus_wvalid), .bus_wready(bus_wready), .bus_wdata(bus_wdata), .bus_wbe(bus_wbe),
    .bus_rvalid(bus_rvalid), .bus_rready(bus_rready), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit in_r10 = 0;
  bit hold_w = 0;
  bit hold_r = 0;

  // Reference model state
  logic [35:0] wq[$];
  logic [2:0]  m_wcfg = '0;
  logic [2:0]  m_rcfg = '0;
  int          m_rcnt = 0;
  bit          m_hv = 0;
  logic [31:0] m_racc = '0;

  function automatic string tag_of(input logic [2:0] c);
    if (!c[2]) return c[1] ? "R2" : "R1";
    if (!c[1]) return "R5";
    return c[0] ? "R3" : "R4";
  endfunction

  // Expected bus beats for a host word: {be, data} per beat.
  function automatic void mk_beats(input logic [2:0] c, input logic [31:0] d, input logic [3:0] e,
                                   output logic [35:0] b0, output logic [35:0] b1, output int n);
    logic [7:0] x0, x1, x2, x3;
    x0 = d[7:0]; x1 = d[15:8]; x2 = d[23:16]; x3 = d[31:24];
    b1 = '0;
    n  = c[2] ? 2 : 1;
    if (!c[2] && !c[1]) b0 = {e, d};
    else if (!c[2])     b0 = {e[0], e[1], e[2], e[3], x0, x1, x2, x3};
    else if (!c[1]) begin
      b0 = {2'b00, e[1], e[0], 16'h0, x1, x0};
      b1 = {2'b00, e[3], e[2], 16'h0, x3, x2};
    end else if (c[0]) begin
      b0 = {e[0], e[1], 2'b00, x0, x1, 16'h0};
      b1 = {e[2], e[3], 2'b00, x2, x3, 16'h0};
    end else begin
      b0 = {2'b00, e[0], e[1], 16'h0, x0, x1};
      b1 = {2'b00, e[2], e[3], 16'h0, x2, x3};
    end
  endfunction

  function automatic logic [31:0] merge(input logic [2:0] c, input int cnt,
                                        input logic [31:0] bt, input logic [31:0] a);
    if (!c[2] && !c[1]) return bt;
    if (!c[2]) return {bt[7:0], bt[15:8], bt[23:16], bt[31:24]};
    if (!c[1]) return (cnt == 0) ? {a[31:16], bt[15:0]} : {bt[15:0], a[15:0]};
    if (c[0])  return (cnt == 0) ? {a[31:16], bt[23:16], bt[31:24]}
                                 : {bt[23:16], bt[31:24], a[15:0]};
    return (cnt == 0) ? {a[31:16], bt[7:0], bt[15:8]} : {bt[7:0], bt[15:8], a[15:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      wq.delete(); m_hv = 0; m_rcnt = 0;
    end else begin
      if (wq.size() != 0) begin
        if (bus_wready) void'(wq.pop_front());
      end else if (wr_valid) begin
        logic [35:0] b0, b1; int n;
        m_wcfg = {cfg_bus16, cfg_big, cfg_upper};
        mk_beats(m_wcfg, wr_data, wr_be, b0, b1, n);
        wq.push_back(b0);
        if (n == 2) wq.push_back(b1);
      end
      if (m_hv) begin
        if (rd_ready) m_hv = 0;
      end else if (bus_rvalid) begin
        if (m_rcnt == 0) m_rcfg = {cfg_bus16, cfg_big, cfg_upper};
        m_racc = merge(m_rcfg, m_rcnt, bus_rdata, m_racc);
        if (m_rcfg[2] && m_rcnt == 0) m_rcnt = 1;
        else begin m_rcnt = 0; m_hv = 1; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(wr_ready == (wq.size() == 0), "R7 wr_ready", 36'(wr_ready), 36'(wq.size() == 0));
      chk(bus_wvalid == (wq.size() != 0), "R7 bus_wvalid", 36'(bus_wvalid), 36'(wq.size() != 0));
      if (wq.size() != 0 && bus_wvalid) begin
        chk(bus_wdata == wq[0][31:0], in_r10 ? "R10 bus_wdata" : tag_of(m_wcfg),
            36'(bus_wdata), 36'(wq[0][31:0]));
        chk(bus_wbe == wq[0][35:32], "R6 bus_wbe", 36'(bus_wbe), 36'(wq[0][35:32]));
      end
      chk(bus_rready == !m_hv, "R9 bus_rready", 36'(bus_rready), 36'(!m_hv));
      chk(rd_valid == m_hv, "R8 rd_valid", 36'(rd_valid), 36'(m_hv));
      if (m_hv && rd_valid)
        chk(rd_data == m_racc, in_r10 ? "R10 rd_data" : "R8 rd_data", 36'(rd_data), 36'(m_racc));
    end
  end

  // Back-pressure drivers
  initial begin
    forever begin
      @(posedge clk); #1;
      bus_wready = hold_w ? 1'b0 : 1'($urandom % 3 != 0);
      rd_ready   = hold_r ? 1'b0 : 1'($urandom % 3 != 0);
    end
  end

  task automatic set_cfg(input logic [2:0] c);
    @(posedge clk); #1;
    {cfg_bus16, cfg_big, cfg_upper} = c;
  endtask

  task automatic host_write(input logic [31:0] d, input logic [3:0] e);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = d; wr_be = e;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic bus_beat(input logic [31:0] d);
    @(posedge clk); #1;
    bus_rvalid = 1; bus_rdata = d;
    forever begin
      @(negedge clk);
      if (bus_rready) break;
    end
    @(posedge clk); #1;
    bus_rvalid = 0;
  endtask

  task automatic host_read_word(input logic [2:0] c, input logic [31:0] w);
    logic [35:0] b0, b1; int n;
    mk_beats(c, w, 4'hF, b0, b1, n);
    bus_beat(b0[31:0]);
    if (n == 2) bus_beat(b1[31:0]);
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (wq.size() == 0 && !m_hv) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual cycles %0d expected below %0d", 150000, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] modes [6];
    logic [31:0] w;
    modes[0] = 3'b000; modes[1] = 3'b010; modes[2] = 3'b111;
    modes[3] = 3'b110; modes[4] = 3'b100; modes[5] = 3'b101;

    // R11: idle outputs during and after reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!bus_wvalid && !rd_valid && wr_ready && bus_rready, "R11 in reset",
        36'({bus_wvalid, rd_valid, wr_ready, bus_rready}), 36'(4'b0011));
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!bus_wvalid && !rd_valid && wr_ready && bus_rready, "R11 after reset",
        36'({bus_wvalid, rd_valid, wr_ready, bus_rready}), 36'(4'b0011));

    // Directed sanity beat: R2 fixed word
    set_cfg(3'b010);
    host_write(32'h44332211, 4'b0001);
    drain();

    for (int m = 0; m < 6; m++) begin
      set_cfg(modes[m]);
      for (int i = 0; i < 20; i++) host_write($urandom, 4'($urandom));
      drain();
      for (int i = 0; i < 20; i++) begin
        w = $urandom;
        host_read_word(modes[m], w);
      end
      drain();
    end

    // R10 write side: flip config while the second beat waits
    set_cfg(3'b111);
    hold_w = 1;
    in_r10 = 1;
    host_write(32'hA1B2C3D4, 4'b1011);
    set_cfg(3'b000);
    repeat (3) @(posedge clk);
    hold_w = 0;
    drain();

    // R10 read side: flip config between the two beats
    set_cfg(3'b110);
    hold_r = 1;
    bus_beat(32'h0000_5A6B);
    set_cfg(3'b010);
    bus_beat(32'h0000_7C8D);
    @(negedge clk);
    chk(rd_valid && rd_data == 32'h8D7C6B5A, "R10 read packed with old mode",
        36'(rd_data), 36'(32'h8D7C6B5A));
    hold_r = 0;
    drain();
    in_r10 = 0;

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule